// File: doc/BRIEF.md
# Wiper Register Command Unit

This block keeps the settings of three digital wiper channels: two wide channels (9 bits, 512 positions) and one narrow channel (7 bits, 128 positions). A host changes them in two ways. It can write a register directly. It can also send a 4-bit command that acts on one chosen channel or on all three channels together. Commands step a value up or down by one or by a factor of two, copy a register into its nonvolatile shadow word, or reload registers from the shadow.

The shadow is a small internal register array with a settable busy time. It stands in for a slow nonvolatile memory. A write-lock input freezes both the registers and the shadow, but restore operations still work while it is active. A reload input brings every register back from the shadow, as a hardware reset pin would.

Control is a three-state machine:
- **ST_RESTORE** is entered at power-up, on `reload_i`, and on a restore command. It lasts `RESTORE_CYC` cycles, then copies the shadow into the masked channels and moves to ST_IDLE.
- **ST_STORE** is entered on an accepted store command. It lasts `STORE_CYC` cycles and then returns to ST_IDLE.
- **ST_IDLE** accepts requests in priority order: `reload_i` first, then a command, then a direct write.

Top module: `wiper_cmd_unit`

## Requirements
- R1: When reset is released, the unit is busy for RESTORE_CYC cycles. The wipers hold midscale throughout: 256, 256 and 64. The shadow also resets to midscale.
- R2: In ST_IDLE, with the lock off, a direct write loads the wiper at the next edge. The narrow channel keeps only data bits [6:0]. A write to channel select 3 changes nothing.
- R3: Command 1010 raises the selected channel by one and 1011 raises all channels by one. Command 0101 lowers the selected channel by one and 0110 lowers all channels by one. Raising saturates at full scale and lowering saturates at zero; neither wraps.
- R4: Command 1000 doubles the selected channel and 1001 doubles all channels. Zero becomes 1. A value at or above midscale becomes full scale. Any other value is shifted left by one.
- R5: Command 0011 halves the selected channel and 0100 halves all channels, using a logical right shift.
- R6: Command 0010 copies the selected channel into its shadow word and keeps busy high for STORE_CYC cycles.
- R7: Command 0001 restores the selected channel. Command 0111 and the `reload_i` input restore all channels. In each case busy stays high for RESTORE_CYC cycles and the registers then hold the shadow values.
- R8: NOP (0000) and the reserved codes 1100 to 1111 change no register and do not set busy. A single-channel command with channel select 3 also changes nothing.
- R9: While `wr_lock_i` is high, direct writes, store commands and step commands change neither registers nor shadow, and a store does not set busy. Restore commands and `reload_i` still reload the registers.
- R10: While busy, a command strobe is ignored and `cmd_err_o` is high for exactly the following cycle. When the unit is idle, `cmd_err_o` stays low.
- R11: If several requests arrive in the same idle cycle, `reload_i` wins over a command, and a command wins over a direct write. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reload_i | input | 1 | Request to reload all wipers from the shadow |
| wr_lock_i | input | 1 | Write lock, active high |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 4 | Command code |
| cmd_chan_i | input | 2 | Channel chosen by single-channel commands |
| wr_en_i | input | 1 | Direct write strobe |
| wr_chan_i | input | 2 | Channel for a direct write |
| wr_data_i | input | 9 | Data for a direct write |
| wiper0_o | output | 9 | Channel 0 wiper code |
| wiper1_o | output | 9 | Channel 1 wiper code |
| wiper2_o | output | 7 | Channel 2 wiper code |
| busy_o | output | 1 | High while a store or restore is running |
| cmd_err_o | output | 1 | One-cycle pulse when a command arrives while busy |

## Verification
A wrong register value shows on the wiper outputs one edge after the command or write that produced it. The only exception is a wrong shadow word. That stays hidden until a restore, and then appears on the wiper RESTORE_CYC cycles after the restore starts. For that reason every store check ends with a restore that reads the value back. A stuck or mistimed state machine shows up as a busy window of the wrong length, or as `cmd_err_o` on an idle command. Both are visible within STORE_CYC cycles.

// File: rtl/wcu_pkg.sv
package wcu_pkg;

    localparam logic [3:0] CMD_NOP         = 4'h0;
    localparam logic [3:0] CMD_RESTORE_ONE = 4'h1;
    localparam logic [3:0] CMD_STORE_ONE   = 4'h2;
    localparam logic [3:0] CMD_HALF_ONE    = 4'h3;
    localparam logic [3:0] CMD_HALF_ALL    = 4'h4;
    localparam logic [3:0] CMD_DEC_ONE     = 4'h5;
    localparam logic [3:0] CMD_DEC_ALL     = 4'h6;
    localparam logic [3:0] CMD_RESTORE_ALL = 4'h7;
    localparam logic [3:0] CMD_DBL_ONE     = 4'h8;
    localparam logic [3:0] CMD_DBL_ALL     = 4'h9;
    localparam logic [3:0] CMD_INC_ONE     = 4'hA;
    localparam logic [3:0] CMD_INC_ALL     = 4'hB;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_DEC,
        OP_DBL,
        OP_HALF
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STORE,
        ST_RESTORE
    } state_e;

    // The last channel is the narrow one; all others are wide.
    function automatic int chan_width(input int idx, input int nch,
                                      input int wide, input int narrow);
        return (idx == nch - 1) ? narrow : wide;
    endfunction

endpackage

// File: rtl/wcu_step.sv
module wcu_step
    import wcu_pkg::*;
#(
    parameter int W = 9
) (
    input  logic [W-1:0] val_i,
    input  op_e          op_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] FULL = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    always_comb begin
        unique case (op_i)
            OP_INC:  val_o = (val_i == FULL) ? FULL : val_i + ONE;
            OP_DEC:  val_o = (val_i == '0) ? '0 : val_i - ONE;
            OP_DBL: begin
                if (val_i == '0)
                    val_o = ONE;
                else if (val_i[W-1])
                    val_o = FULL;
                else
                    val_o = {val_i[W-2:0], 1'b0};
            end
            OP_HALF: val_o = val_i >> 1;
            default: val_o = val_i;
        endcase
    end
endmodule

// File: rtl/wcu_shadow.sv
module wcu_shadow
    import wcu_pkg::*;
#(
    parameter int NCH         = 3,
    parameter int WIDE_W      = 9,
    parameter int NARROW_W    = 7,
    parameter int STORE_CYC   = 40,
    parameter int RESTORE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_go_i,
    input  logic [NCH-1:0]    st_mask_i,
    input  logic [WIDE_W-1:0] st_data_i [NCH],
    input  logic              rs_go_i,
    output logic              done_o,
    output logic [WIDE_W-1:0] rd_data_o [NCH]
);
    localparam int MAXC = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= CW'(RESTORE_CYC);
        else if (st_go_i)
            cnt_q <= CW'(STORE_CYC);
        else if (rs_go_i)
            cnt_q <= CW'(RESTORE_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign done_o = (cnt_q == CW'(1));

    for (genvar g = 0; g < NCH; g++) begin : g_word
        localparam int W = chan_width(g, NCH, WIDE_W, NARROW_W);
        localparam logic [WIDE_W-1:0] MID = WIDE_W'(1) << (W - 1);
        logic [WIDE_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= MID;
            else if (st_go_i && st_mask_i[g])
                word_q <= st_data_i[g];
        end
        assign rd_data_o[g] = word_q;
    end

    AST_GO_ONLY_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_go_i || rs_go_i) |-> (cnt_q == '0)) else $error("go while timing"); // R10
endmodule

// File: rtl/wiper_cmd_unit.sv
module wiper_cmd_unit
    import wcu_pkg::*;
#(
    parameter int WIDE_W      = 9,
    parameter int NARROW_W    = 7,
    parameter int STORE_CYC   = 40,
    parameter int RESTORE_CYC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reload_i,
    input  logic                wr_lock_i,
    input  logic                cmd_valid_i,
    input  logic [3:0]          cmd_code_i,
    input  logic [1:0]          cmd_chan_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_chan_i,
    input  logic [WIDE_W-1:0]   wr_data_i,
    output logic [WIDE_W-1:0]   wiper0_o,
    output logic [WIDE_W-1:0]   wiper1_o,
    output logic [NARROW_W-1:0] wiper2_o,
    output logic                busy_o,
    output logic                cmd_err_o
);
    localparam int NCH  = 3;
    localparam int SELW = 2;

    state_e            state_q, state_nx;
    logic [NCH-1:0]    rs_mask_q, rs_mask_nx, sel_mask, arith_mask;
    op_e               arith_op;
    op_e               op_vec [NCH];
    logic              chan_ok, is_idle, st_go, rs_go, wr_go, sh_done, err_q;
    logic [WIDE_W-1:0] st_bus [NCH];
    logic [WIDE_W-1:0] sh_rd  [NCH];

    assign is_idle  = (state_q == ST_IDLE);
    assign chan_ok  = (cmd_chan_i < SELW'(NCH));
    assign sel_mask = chan_ok ? (NCH'(1) << cmd_chan_i) : '0;

    // Request decode and next-state selection
    always_comb begin
        state_nx   = state_q;
        rs_mask_nx = rs_mask_q;
        st_go      = 1'b0;
        rs_go      = 1'b0;
        wr_go      = 1'b0;
        arith_op   = OP_HOLD;
        arith_mask = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (reload_i) begin
                    rs_go      = 1'b1;
                    rs_mask_nx = '1;
                    state_nx   = ST_RESTORE;
                end else if (cmd_valid_i) begin
                    case (cmd_code_i)
                        CMD_RESTORE_ONE: if (chan_ok) begin
                            rs_go      = 1'b1;
                            rs_mask_nx = sel_mask;
                            state_nx   = ST_RESTORE;
                        end
                        CMD_RESTORE_ALL: begin
                            rs_go      = 1'b1;
                            rs_mask_nx = '1;
                            state_nx   = ST_RESTORE;
                        end
                        CMD_STORE_ONE: if (chan_ok && !wr_lock_i) begin
                            st_go    = 1'b1;
                            state_nx = ST_STORE;
                        end
                        CMD_HALF_ONE: begin arith_op = OP_HALF; arith_mask = sel_mask; end
                        CMD_HALF_ALL: begin arith_op = OP_HALF; arith_mask = '1;       end
                        CMD_DEC_ONE:  begin arith_op = OP_DEC;  arith_mask = sel_mask; end
                        CMD_DEC_ALL:  begin arith_op = OP_DEC;  arith_mask = '1;       end
                        CMD_DBL_ONE:  begin arith_op = OP_DBL;  arith_mask = sel_mask; end
                        CMD_DBL_ALL:  begin arith_op = OP_DBL;  arith_mask = '1;       end
                        CMD_INC_ONE:  begin arith_op = OP_INC;  arith_mask = sel_mask; end
                        CMD_INC_ALL:  begin arith_op = OP_INC;  arith_mask = '1;       end
                        default: ;
                    endcase
                    if (wr_lock_i)
                        arith_mask = '0;
                end else if (wr_en_i && !wr_lock_i && (wr_chan_i < SELW'(NCH))) begin
                    wr_go = 1'b1;
                end
            end
            ST_STORE:   if (sh_done) state_nx = ST_IDLE;
            ST_RESTORE: if (sh_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RESTORE;
        else
            state_q <= state_nx;
    end

    // Output-side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_mask_q <= '1;
            err_q     <= 1'b0;
        end else begin
            rs_mask_q <= rs_mask_nx;
            err_q     <= cmd_valid_i && !is_idle;
        end
    end

    assign busy_o    = !is_idle;
    assign cmd_err_o = err_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int W = chan_width(g, NCH, WIDE_W, NARROW_W);
        localparam logic [W-1:0] MID = W'(1) << (W - 1);
        logic [W-1:0] wip_q, step_nx;

        assign op_vec[g] = arith_mask[g] ? arith_op : OP_HOLD;

        wcu_step #(.W(W)) u_step (
            .val_i (wip_q),
            .op_i  (op_vec[g]),
            .val_o (step_nx)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                wip_q <= MID;
            else if (arith_mask[g])
                wip_q <= step_nx;
            else if (wr_go && (wr_chan_i == SELW'(g)))
                wip_q <= wr_data_i[W-1:0];
            else if ((state_q == ST_RESTORE) && sh_done && rs_mask_q[g])
                wip_q <= sh_rd[g][W-1:0];
        end

        assign st_bus[g] = WIDE_W'(wip_q);

        if (W < WIDE_W) begin : g_pad
            logic unused_hi;
            assign unused_hi = ^sh_rd[g][WIDE_W-1:W];
        end

        if (g == 0) begin : g_o0
            assign wiper0_o = wip_q;
        end else if (g == 1) begin : g_o1
            assign wiper1_o = wip_q;
        end else begin : g_o2
            assign wiper2_o = wip_q;
        end
    end

    wcu_shadow #(
        .NCH         (NCH),
        .WIDE_W      (WIDE_W),
        .NARROW_W    (NARROW_W),
        .STORE_CYC   (STORE_CYC),
        .RESTORE_CYC (RESTORE_CYC)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_go_i   (st_go),
        .st_mask_i (sel_mask),
        .st_data_i (st_bus),
        .rs_go_i   (rs_go),
        .done_o    (sh_done),
        .rd_data_o (sh_rd)
    );

    AST_ERR_ON_BUSY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && busy_o) |=> cmd_err_o) else $error("missing error pulse"); // R10
    AST_NO_ERR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !cmd_err_o) else $error("spurious error pulse"); // R10
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && wr_lock_i && !reload_i &&
         !(cmd_valid_i && (cmd_code_i == CMD_RESTORE_ONE || cmd_code_i == CMD_RESTORE_ALL)))
        |=> ($stable(wiper0_o) && $stable(wiper1_o) && $stable(wiper2_o)))
        else $error("wiper moved under lock"); // R9
    AST_INC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && cmd_valid_i && cmd_code_i == CMD_INC_ALL && !wr_lock_i && !reload_i)
        |=> (wiper0_o >= $past(wiper0_o))) else $error("increment wrapped"); // R3
    AST_DEC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && cmd_valid_i && cmd_code_i == CMD_DEC_ALL && !wr_lock_i && !reload_i)
        |=> (wiper0_o <= $past(wiper0_o))) else $error("decrement wrapped"); // R3
    AST_DBL_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && cmd_valid_i && cmd_code_i == CMD_DBL_ALL && !wr_lock_i && !reload_i
         && wiper2_o == '0) |=> (wiper2_o == NARROW_W'(1))) else $error("zero doubling"); // R4
    AST_STORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && cmd_valid_i && cmd_code_i == CMD_STORE_ONE && chan_ok && !wr_lock_i
         && !reload_i) |=> busy_o) else $error("store not busy"); // R6
endmodule

// File: tb/test_wiper_cmd_unit.sv
module test_wiper_cmd_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ST_CYC     = 12;
    localparam int RS_CYC     = 5;

    typedef struct packed {
        logic       kind;   // 0 = direct write, 1 = command
        logic [3:0] code;
        logic [1:0] chan;
        logic [8:0] data;
        logic [8:0] e0;
        logic [8:0] e1;
        logic [6:0] e2;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'h0, 2'd0, 9'd0,   9'd0, 9'd256, 7'd64},  // R2
        '{1'b1, 4'h8, 2'd0, 9'd0,   9'd1, 9'd256, 7'd64},  // R4 zero -> 1
        '{1'b1, 4'h9, 2'd0, 9'd0,   9'd2, 9'd511, 7'd127}, // R4 mid -> full
        '{1'b1, 4'hB, 2'd0, 9'd0,   9'd3, 9'd511, 7'd127}, // R3 saturate
        '{1'b1, 4'h4, 2'd0, 9'd0,   9'd1, 9'd255, 7'd63},  // R5
        '{1'b1, 4'h3, 2'd1, 9'd0,   9'd1, 9'd127, 7'd63},  // R5
        '{1'b1, 4'h5, 2'd0, 9'd0,   9'd0, 9'd127, 7'd63},  // R3
        '{1'b1, 4'h5, 2'd0, 9'd0,   9'd0, 9'd127, 7'd63},  // R3 floor
        '{1'b1, 4'h6, 2'd0, 9'd0,   9'd0, 9'd126, 7'd62},  // R3
        '{1'b0, 4'h0, 2'd2, 9'd511, 9'd0, 9'd126, 7'd127}, // R2 narrow
        '{1'b1, 4'hA, 2'd2, 9'd0,   9'd0, 9'd126, 7'd127}, // R3 saturate
        '{1'b0, 4'h0, 2'd1, 9'd200, 9'd0, 9'd200, 7'd127}, // R2
        '{1'b1, 4'h8, 2'd1, 9'd0,   9'd0, 9'd400, 7'd127}, // R4
        '{1'b1, 4'h3, 2'd2, 9'd0,   9'd0, 9'd400, 7'd63},  // R5
        '{1'b1, 4'h0, 2'd0, 9'd0,   9'd0, 9'd400, 7'd63},  // R8 nop
        '{1'b1, 4'hC, 2'd0, 9'd0,   9'd0, 9'd400, 7'd63},  // R8 reserved
        '{1'b1, 4'hF, 2'd1, 9'd0,   9'd0, 9'd400, 7'd63},  // R8 reserved
        '{1'b1, 4'hA, 2'd3, 9'd0,   9'd0, 9'd400, 7'd63},  // R8 chan 3
        '{1'b0, 4'h0, 2'd3, 9'd5,   9'd0, 9'd400, 7'd63},  // R2 chan 3
        '{1'b1, 4'hA, 2'd0, 9'd0,   9'd1, 9'd400, 7'd63},  // R3
        '{1'b1, 4'h9, 2'd0, 9'd0,   9'd2, 9'd511, 7'd126}, // R4
        '{1'b1, 4'h4, 2'd0, 9'd0,   9'd1, 9'd255, 7'd63},  // R5
        '{1'b1, 4'h9, 2'd0, 9'd0,   9'd2, 9'd510, 7'd126}, // R4
        '{1'b1, 4'h8, 2'd2, 9'd0,   9'd2, 9'd510, 7'd127}  // R4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reload_i = 1'b0;
    logic       wr_lock_i = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [3:0] cmd_code_i = '0;
    logic [1:0] cmd_chan_i = '0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_chan_i = '0;
    logic [8:0] wr_data_i = '0;
    logic [8:0] wiper0_o, wiper1_o;
    logic [6:0] wiper2_o;
    logic       busy_o, cmd_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    int n_busy;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wiper_cmd_unit #(.STORE_CYC(ST_CYC), .RESTORE_CYC(RS_CYC)) i_wiper_cmd_unit (
        .clk (clk), .rst_n (rst_n), .reload_i (reload_i), .wr_lock_i (wr_lock_i),
        .cmd_valid_i (cmd_valid_i), .cmd_code_i (cmd_code_i), .cmd_chan_i (cmd_chan_i),
        .wr_en_i (wr_en_i), .wr_chan_i (wr_chan_i), .wr_data_i (wr_data_i),
        .wiper0_o (wiper0_o), .wiper1_o (wiper1_o), .wiper2_o (wiper2_o),
        .busy_o (busy_o), .cmd_err_o (cmd_err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_w(input string tag, input int e0, input int e1, input int e2);
        chk({tag, " ch0"}, wiper0_o, e0);
        chk({tag, " ch1"}, wiper1_o, e1);
        chk({tag, " ch2"}, wiper2_o, e2);
    endtask

    task automatic send_cmd(input logic [3:0] code, input logic [1:0] chan);
        @(negedge clk);
        cmd_valid_i = 1'b1; cmd_code_i = code; cmd_chan_i = chan;
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic send_wr(input logic [1:0] chan, input logic [8:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_chan_i = chan; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_w("R1 in reset", 256, 256, 64);
        rst_n = 1'b1;
        chk("R1 busy at release", busy_o, 1);
        wait_idle(n_busy);
        chk("R1 power-up busy length", n_busy, RS_CYC);
        chk_w("R1 after power-up", 256, 256, 64);
        chk("R10 no error at idle", cmd_err_o, 0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].kind)
                send_cmd(VECS[i].code, VECS[i].chan);
            else
                send_wr(VECS[i].chan, VECS[i].data);
            chk_w($sformatf("vector %0d", i), VECS[i].e0, VECS[i].e1, VECS[i].e2);
            chk($sformatf("R8 vector %0d busy", i), busy_o, 0);
        end

        // R6 and R7: store, overwrite, restore one, restore all, reload input
        send_wr(2'd0, 9'd77);
        send_cmd(4'h2, 2'd0);
        wait_idle(n_busy);
        chk("R6 store busy length", n_busy, ST_CYC);
        send_wr(2'd0, 9'd5);
        chk("R2 overwrite ch0", wiper0_o, 5);
        send_cmd(4'h1, 2'd0);
        wait_idle(n_busy);
        chk("R7 restore busy length", n_busy, RS_CYC);
        chk_w("R7 restore one", 77, 510, 127);
        send_wr(2'd1, 9'd300);
        send_cmd(4'h7, 2'd3);
        wait_idle(n_busy);
        chk_w("R7 restore all", 77, 256, 64);
        send_wr(2'd2, 9'd10);
        @(negedge clk); reload_i = 1'b1;
        @(negedge clk); reload_i = 1'b0;
        chk("R7 reload busy", busy_o, 1);
        wait_idle(n_busy);
        chk_w("R7 reload input", 77, 256, 64);

        // R9: lock
        send_wr(2'd0, 9'd33);
        wr_lock_i = 1'b1;
        send_wr(2'd0, 9'd9);
        chk_w("R9 write locked", 33, 256, 64);
        send_cmd(4'hB, 2'd0);
        chk_w("R9 step locked", 33, 256, 64);
        send_cmd(4'h2, 2'd0);
        chk("R9 store not busy", busy_o, 0);
        send_cmd(4'h1, 2'd0);
        wait_idle(n_busy);
        chk("R9 restore under lock", wiper0_o, 77);
        wr_lock_i = 1'b0;

        // R10: command while busy
        send_cmd(4'h2, 2'd2);
        cmd_valid_i = 1'b1; cmd_code_i = 4'hB; cmd_chan_i = 2'd0;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        chk("R10 error pulse", cmd_err_o, 1);
        @(negedge clk);
        chk("R10 error one cycle", cmd_err_o, 0);
        wait_idle(n_busy);
        chk_w("R10 busy command ignored", 77, 256, 64);

        // R11: priority
        send_wr(2'd1, 9'd9);
        @(negedge clk);
        reload_i = 1'b1; cmd_valid_i = 1'b1; cmd_code_i = 4'hB; cmd_chan_i = 2'd0;
        wr_en_i = 1'b1; wr_chan_i = 2'd0; wr_data_i = 9'd0;
        @(negedge clk);
        reload_i = 1'b0; cmd_valid_i = 1'b0; wr_en_i = 1'b0;
        chk("R11 reload wins busy", busy_o, 1);
        wait_idle(n_busy);
        chk_w("R11 reload wins", 77, 256, 64);
        @(negedge clk);
        cmd_valid_i = 1'b1; cmd_code_i = 4'hA; cmd_chan_i = 2'd0;
        wr_en_i = 1'b1; wr_chan_i = 2'd0; wr_data_i = 9'd0;
        @(negedge clk);
        cmd_valid_i = 1'b0; wr_en_i = 1'b0;
        chk("R11 command beats write", wiper0_o, 78);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule